// File: doc/BRIEF.md
# Serial Port Status Flags and Interrupt Requests

This block holds the status flags of a synchronous serial port and turns them into interrupt requests. Four flags are kept: received word waiting, transmit holding register empty, transmit line idle, and receive overrun. A shift engine reports events (word received, word taken for shifting, transfer finished); the CPU clears flags by reading the receive data register, writing the transmit data register, or writing a command bit.

A small configuration register holds three interrupt enables and the receive-FIFO enable, plus two write-1 command bits that always read back as 0: one clears the overrun flag, the other is a software reset. The software reset zeroes all four flags and pulses an output that tells the shifter to abort its transfer and the baud divider to reload and restart, while the configuration fields stay as they are.

Top module: `ser_stat_irq`

## Requirements
- R1: After the asynchronous reset, status_o reads 4'b0110 (bit 0 received-word=0, bit 1 tx-empty=1, bit 2 tx-idle=1, bit 3 overrun=0), cfg_rdata_o reads 0 and all three interrupt outputs are 0.
- R2: irq_rx_o is 1 exactly when config bit 0 is 1 and either status bit 0 or status bit 3 is 1.
- R3: irq_tx_o is 1 exactly when config bit 1 is 1 and status bit 1 is 1.
- R4: irq_idle_o is 1 exactly when config bit 2 is 1 and status bit 2 is 1.
- R5: rx_done_i sets status bit 0 and rd_data_i clears it. Overrun (bit 3) sets when rx_done_i arrives while bit 0 is 1 and rd_data_i is not asserted in the same cycle.
- R6: Overrun is cleared only by a configuration write with bit 4 set; writing bit 4 as 0 leaves it unchanged, and cfg_rdata_o bit 4 always reads 0.
- R7: When overrun sets while the receive-FIFO enable (config bit 3) is 1, that enable is cleared in the same cycle the flag sets, overriding a configuration write in that cycle.
- R8: A configuration write with bit 5 set makes all four flags 0 and raises sw_reset_o for exactly one cycle, both in the cycle after the write; config bits 3:0 take the written value as on any write, and cfg_rdata_o bit 5 always reads 0.
- R9: wr_data_i clears status bits 1 and 2; tx_load_i sets bit 1; tx_end_i sets bit 2 when bit 1 is 1 in that cycle.
- R10: When a set event and a clear for the same flag arrive in one cycle, the flag ends up 1.
- R11: A software reset wins over every flag set event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_done_i | input | 1 | Shifter completed a received word |
| tx_load_i | input | 1 | Shifter took the transmit word |
| tx_end_i | input | 1 | Shifter finished a transfer |
| rd_data_i | input | 1 | CPU read of the receive data register |
| wr_data_i | input | 1 | CPU write of the transmit data register |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 6 | Configuration write data |
| cfg_rdata_o | output | 6 | Configuration read-back, command bits as 0 |
| status_o | output | 4 | Flags: 0 rx word, 1 tx empty, 2 tx idle, 3 overrun |
| irq_rx_o | output | 1 | Receive interrupt request |
| irq_tx_o | output | 1 | Transmit interrupt request |
| irq_idle_o | output | 1 | Transmit idle interrupt request |
| rx_fifo_en_o | output | 1 | Receive-FIFO enable |
| sw_reset_o | output | 1 | One-cycle abort and baud-restart pulse |

## Verification
Every flag, configuration field and the sw_reset_o pulse is a register, so a stimulus sampled at one rising edge shows on the outputs right after that edge; the interrupt outputs are combinational from those registers and move in the same cycle. The bench drives inputs at the falling edge, advances its own model of the flags at the next rising edge, and compares all outputs 1 ns later. Directed steps cover each rule and same-cycle conflicts, followed by a long pseudo-random sweep over all event and write combinations.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;
  localparam int FLAG_N   = 4;
  localparam int F_RDF    = 0;
  localparam int F_TDE    = 1;
  localparam int F_IDLE   = 2;
  localparam int F_OVR    = 3;
  localparam logic [FLAG_N-1:0] FLAG_RST = 4'b0110;

  localparam int FIELD_W  = 4;
  localparam int CFG_W    = 6;
  localparam int C_EN_RX  = 0;
  localparam int C_EN_TX  = 1;
  localparam int C_EN_IDL = 2;
  localparam int C_FIFO   = 3;
  localparam int C_ERRCLR = 4;
  localparam int C_SWRST  = 5;
endpackage

// File: rtl/ser_flag_bank.sv
module ser_flag_bank #(
  parameter int N = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_r <= RST_VAL[i];
      else if (flush_i)   q_r <= 1'b0;
      else if (set_i[i])  q_r <= 1'b1;   // set beats clear
      else if (clr_i[i])  q_r <= 1'b0;
    end
    assign q_o[i] = q_r;

    p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[i] && clr_i[i] && !flush_i) |=> q_r);
    p_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> !q_r);
  end
endmodule

// File: rtl/ser_cfg_reg.sv
module ser_cfg_reg
  import ser_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             fifo_kill_i,
  output logic [FIELD_W-1:0] field_o,
  output logic             err_clr_o,
  output logic             soft_rst_o,
  output logic             sw_reset_q_o,
  output logic [CFG_W-1:0] rdata_o
);
  logic [FIELD_W-1:0] field_q;
  logic               pulse_q;

  assign err_clr_o  = we_i & wdata_i[C_ERRCLR];
  assign soft_rst_o = we_i & wdata_i[C_SWRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (we_i) field_q <= wdata_i[FIELD_W-1:0];
      if (fifo_kill_i) field_q[C_FIFO] <= 1'b0;  // overrun kill beats write
      pulse_q <= soft_rst_o;
    end
  end

  assign field_o      = field_q;
  assign sw_reset_q_o = pulse_q;
  assign rdata_o      = {{(CFG_W-FIELD_W){1'b0}}, field_q};

  p_fifo_kill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_kill_i |=> !field_q[C_FIFO]);
  p_pulse_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && !soft_rst_o) |=> !pulse_q);
endmodule

// File: rtl/ser_irq_gen.sv
module ser_irq_gen
  import ser_stat_pkg::*;
(
  input  logic [FLAG_N-1:0]  flag_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic               irq_rx_o,
  output logic               irq_tx_o,
  output logic               irq_idle_o
);
  always_comb begin
    irq_rx_o   = field_i[C_EN_RX]  & (flag_i[F_RDF] | flag_i[F_OVR]);
    irq_tx_o   = field_i[C_EN_TX]  & flag_i[F_TDE];
    irq_idle_o = field_i[C_EN_IDL] & flag_i[F_IDLE];
  end
endmodule

// File: rtl/ser_stat_irq.sv
module ser_stat_irq
  import ser_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_done_i,
  input  logic             tx_load_i,
  input  logic             tx_end_i,
  input  logic             rd_data_i,
  input  logic             wr_data_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic [FLAG_N-1:0] status_o,
  output logic             irq_rx_o,
  output logic             irq_tx_o,
  output logic             irq_idle_o,
  output logic             rx_fifo_en_o,
  output logic             sw_reset_o
);
  logic [FLAG_N-1:0]  flag_q, set_v, clr_v;
  logic [FIELD_W-1:0] field;
  logic               err_clr, soft_rst, ovr_set;

  assign ovr_set = rx_done_i & flag_q[F_RDF] & ~rd_data_i;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[F_RDF]  = rx_done_i;
    clr_v[F_RDF]  = rd_data_i;
    set_v[F_TDE]  = tx_load_i;
    clr_v[F_TDE]  = wr_data_i;
    set_v[F_IDLE] = tx_end_i & flag_q[F_TDE];  // no word pending
    clr_v[F_IDLE] = wr_data_i;
    set_v[F_OVR]  = ovr_set;
    clr_v[F_OVR]  = err_clr;
  end

  ser_cfg_reg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .wdata_i      (cfg_wdata_i),
    .fifo_kill_i  (ovr_set & ~soft_rst),
    .field_o      (field),
    .err_clr_o    (err_clr),
    .soft_rst_o   (soft_rst),
    .sw_reset_q_o (sw_reset_o),
    .rdata_o      (cfg_rdata_o)
  );

  ser_flag_bank #(.N(FLAG_N), .RST_VAL(FLAG_RST)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (soft_rst),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .q_o     (flag_q)
  );

  ser_irq_gen u_irq (
    .flag_i     (flag_q),
    .field_i    (field),
    .irq_rx_o   (irq_rx_o),
    .irq_tx_o   (irq_tx_o),
    .irq_idle_o (irq_idle_o)
  );

  assign status_o     = flag_q;
  assign rx_fifo_en_o = field[C_FIFO];

  p_ovr_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[F_OVR] && !err_clr && !soft_rst) |=> status_o[F_OVR]);
  p_swrst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (status_o == '0 && sw_reset_o));
  p_rx_irq_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_o |-> (status_o[F_RDF] || status_o[F_OVR]));
  p_ovr_fifo_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[F_OVR]) |-> !rx_fifo_en_o);
  p_tx_irq_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_tx_o |-> status_o[F_TDE]);
endmodule

// File: tb/tb_ser_stat_irq.sv
`timescale 1ns/1ps
module tb_ser_stat_irq;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_done = 0, tx_load = 0, tx_end = 0, rd = 0, wr = 0, we = 0;
  logic [5:0] wd = '0;
  logic [5:0] rdata;
  logic [3:0] status;
  logic irq_rx, irq_tx, irq_idle, fifo_en, swr;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic m_rdf, m_tde, m_idle, m_ovr, m_swr;
  logic [3:0] m_cfg;

  always #2.5 clk = ~clk;

  ser_stat_irq dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_done_i(rx_done), .tx_load_i(tx_load),
    .tx_end_i(tx_end), .rd_data_i(rd), .wr_data_i(wr), .cfg_we_i(we),
    .cfg_wdata_i(wd), .cfg_rdata_o(rdata), .status_o(status),
    .irq_rx_o(irq_rx), .irq_tx_o(irq_tx), .irq_idle_o(irq_idle),
    .rx_fifo_en_o(fifo_en), .sw_reset_o(swr)
  );

  function automatic logic [14:0] expv();
    logic [3:0] st;
    st = {m_ovr, m_idle, m_tde, m_rdf};
    return {m_swr, m_cfg[3], m_cfg[2] & m_idle, m_cfg[1] & m_tde,
            m_cfg[0] & (m_rdf | m_ovr), 2'b00, m_cfg, st};
  endfunction

  function automatic logic [14:0] actv();
    return {swr, fifo_en, irq_idle, irq_tx, irq_rx, rdata, status};
  endfunction

  task automatic chk(string tag);
    checks++;
    if (actv() !== expv()) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, actv(), expv());
    end
  endtask

  // apply one cycle of stimulus, update the model at the edge, compare after it
  task automatic step(string tag, logic a_rx, logic a_rd, logic a_ld, logic a_end,
                      logic a_wr, logic a_we, logic [5:0] a_wd);
    logic srst, oset;
    @(negedge clk);
    rx_done = a_rx; rd = a_rd; tx_load = a_ld; tx_end = a_end; wr = a_wr;
    we = a_we; wd = a_wd;
    @(posedge clk);
    srst = a_we & a_wd[5];
    oset = a_rx & m_rdf & ~a_rd;
    m_swr = srst;
    if (a_we) m_cfg = a_wd[3:0];
    if (srst) begin
      m_rdf = 0; m_tde = 0; m_idle = 0; m_ovr = 0;
    end else begin
      if (oset) m_cfg[3] = 1'b0;
      m_idle = (a_end & m_tde) ? 1'b1 : (a_wr ? 1'b0 : m_idle);
      m_rdf  = a_rx ? 1'b1 : (a_rd ? 1'b0 : m_rdf);
      m_ovr  = oset ? 1'b1 : ((a_we & a_wd[4]) ? 1'b0 : m_ovr);
      m_tde  = a_ld ? 1'b1 : (a_wr ? 1'b0 : m_tde);
    end
    #1;
    chk(tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [31:0] lf;
    m_rdf = 0; m_tde = 1; m_idle = 1; m_ovr = 0; m_swr = 0; m_cfg = '0;
    #12 rst_ni = 1'b1;
    #1 chk("R1 reset");
    // enables on
    step("R3 R4 enables", 0,0,0,0,0, 1, 6'b000111);
    step("R9 wr clears", 0,0,0,0,1, 0, 0);
    step("R9 load sets tde", 0,0,1,0,0, 0, 0);
    step("R9 end sets idle", 0,0,0,1,0, 0, 0);
    step("R9 end no tde", 0,0,0,0,1, 0, 0);
    step("R9 end ignored", 0,0,0,1,0, 0, 0);
    step("R2 R5 rx word", 1,0,0,0,0, 0, 0);
    step("R5 overrun", 1,0,0,0,0, 0, 0);
    step("R2 R6 read keeps ovr", 0,1,0,0,0, 0, 0);
    step("R6 write0 no clear", 0,0,0,0,0, 1, 6'b000111);
    step("R6 err clear", 0,0,0,0,0, 1, 6'b010111);
    step("R7 fifo on", 1,0,0,0,0, 1, 6'b001111);
    step("R7 ovr kills fifo", 1,0,0,0,0, 0, 0);
    step("R7 clear", 0,1,0,0,0, 1, 6'b011111);
    step("R7 kill beats write", 1,0,0,0,0, 0, 0);
    step("R7 kill vs write", 1,0,0,0,0, 1, 6'b001111);
    step("R6 clear again", 0,1,0,0,0, 1, 6'b011111);
    step("R5 R10 rx and read", 1,0,0,0,0, 0, 0);
    step("R5 R10 rx and read", 1,1,0,0,0, 0, 0);
    step("R10 load and wr", 0,0,1,0,1, 0, 0);
    step("R10 end and wr", 0,0,0,1,1, 0, 0);
    step("R8 soft reset", 0,0,0,0,0, 1, 6'b101111);
    step("R8 pulse ends", 0,0,0,0,0, 0, 0);
    step("R11 setup", 0,0,1,0,0, 0, 0);
    step("R11 reset beats set", 1,0,1,1,0, 1, 6'b100101);
    step("R11 after", 0,0,0,0,0, 0, 0);
    // pseudo-random sweep over all event / write combinations
    lf = 32'hACE1_2468;
    for (int i = 0; i < 4000; i++) begin
      logic w, s;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      w = (lf[12:10] == 3'b000);
      s = (lf[20:16] == 5'b00000);
      step("R10 sweep", lf[0], lf[1], lf[2], lf[3], lf[4], w,
           {s, lf[9], lf[8:5]});
    end
    done = 1;
    summary();
  end
endmodule